// File: doc/BRIEF.md
# Segmented Lane Shuffle Unit

This block moves one data word per lane among the lanes of a wavefront in a single pass. Each request carries a word for every lane, an addressing mode, one shared operand (a lane number or a distance), a per-lane source vector, and a segment width. The segment width splits the wavefront into independent groups of equal power-of-two size. In every mode except the free permute, a lane only reads from a lane in its own group.

The result for all lanes is captured in one output register. A valid/ready handshake is used on both sides. A small two-state controller tracks whether that register holds a result. States: `S_EMPTY` (nothing held) and `S_FULL` (a result is waiting). Transitions:
- `S_EMPTY -> S_FULL` when a request is accepted.
- `S_FULL -> S_FULL` when the result is taken and a new request is accepted in the same cycle, or when the result is not taken.
- `S_FULL -> S_EMPTY` when the result is taken and no request arrives.

Mode codes:
| Code | Mode |
|---|---|
| 0 | group broadcast |
| 1 | shift up |
| 2 | XOR |
| 3 | free permute |

Top module: `lane_shuf_top`

## Requirements
- R1: Mode 0 (broadcast): every lane takes the input of the lane at offset (operand mod segment width) inside its own segment.
- R2: Mode 1 (shift up): a lane at offset `k` in its segment, where `k >= operand`, takes the input of the lane `operand` positions below it.
- R3: Mode 1: a lane whose offset is smaller than the operand keeps its own input word. This includes every lane when the operand is at least the segment width.
- R4: Mode 2 (XOR): a lane takes the input of the lane whose segment offset equals (its own offset XOR operand) mod segment width, within the same segment.
- R5: Mode 3 (free permute): lane `i` takes the input of lane `src[i]`, where `src[i]` is the field at bits `[i*LW +: LW]` of `in_src` and LW = log2(lanes). The segment width and the operand are ignored.
- R6: A legal segment width is a power of two from 2 up to the lane count. Segments are aligned at multiples of that width, and in modes 0 to 2 no lane reads outside its segment.
- R7: A segment width that is not legal (0, 1, not a power of two, or above the lane count) behaves exactly like a width equal to the lane count.
- R8: `out_valid` rises in the cycle after a request is accepted. It falls after a result is taken with no new request accepted in the same cycle.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` stays unchanged. A request offered in that time is taken only when the result drains.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_mode | input | 2 | Addressing mode (0 broadcast, 1 shift up, 2 XOR, 3 permute) |
| in_operand | input | LW (5) | Lane offset or distance |
| in_seg_width | input | LW+1 (6) | Segment width in lanes |
| in_data | input | N*W (1024) | One word per lane; lane i at `[i*W +: W]` |
| in_src | input | N*LW (160) | Per-lane source lane for permute mode |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Result taken this cycle |
| out_data | output | N*W (1024) | Shuffled word per lane |

## Verification
Every shuffled result is due exactly one clock edge after the edge that accepts the request. The bench drives a request at a falling edge and lets the next rising edge accept it. It then checks `out_valid` and every lane of `out_data` at the falling edge that follows, half a period after the result is registered. In the backpressure case, the held result is checked at each falling edge over several stalled cycles. The queued request's result is expected one edge after `out_ready` returns high, since the drain and the accept happen on that same edge.

// File: rtl/lane_shuf_pkg.sv
package lane_shuf_pkg;

    typedef enum logic [1:0] {
        MODE_INDEX = 2'd0,
        MODE_UP    = 2'd1,
        MODE_XOR   = 2'd2,
        MODE_PERM  = 2'd3
    } shuf_mode_e;

    typedef enum logic {
        S_EMPTY = 1'b0,
        S_FULL  = 1'b1
    } hold_state_e;

endpackage

// File: rtl/lane_shuf_width.sv
module lane_shuf_width #(
    parameter int N  = 32,
    parameter int LW = $clog2(N),
    parameter int SW = LW + 1
) (
    input  logic [SW-1:0] seg_req,
    output logic [SW-1:0] seg_eff
);
    logic pow2;
    logic in_range;

    always_comb begin
        pow2     = ((seg_req & (seg_req - SW'(1))) == '0);
        in_range = (seg_req >= SW'(2)) && (seg_req <= SW'(N));
        seg_eff  = (pow2 && in_range) ? seg_req : SW'(N);
    end

    always_comb begin
        p_width_legal_r7: assert ($onehot0(seg_eff) && (seg_eff >= SW'(2)))
            else $error("effective segment width not legal");
    end

endmodule

// File: rtl/lane_shuf_route.sv
module lane_shuf_route
    import lane_shuf_pkg::*;
#(
    parameter int N  = 32,
    parameter int W  = 32,
    parameter int LW = $clog2(N),
    parameter int SW = LW + 1
) (
    input  logic [1:0]      mode,
    input  logic [LW-1:0]   operand,
    input  logic [SW-1:0]   seg_w,
    input  logic [N*W-1:0]  data,
    input  logic [N*LW-1:0] srcs,
    output logic [N*W-1:0]  result
);
    logic [W-1:0]  lane_d [N];
    logic [LW-1:0] mask;
    shuf_mode_e    m;

    assign mask = LW'(seg_w - SW'(1));
    assign m    = shuf_mode_e'(mode);

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [LW-1:0] me;
        logic [LW-1:0] base;
        logic [LW-1:0] off;
        logic [LW-1:0] sel;

        assign lane_d[i] = data[i*W +: W];

        always_comb begin
            me   = LW'(i);
            base = me & ~mask;
            off  = me & mask;
            case (m)
                MODE_INDEX: sel = base | (operand & mask);
                MODE_UP:    sel = (off >= operand) ? (me - operand) : me;
                MODE_XOR:   sel = base | ((off ^ operand) & mask);
                MODE_PERM:  sel = srcs[i*LW +: LW];
                default:    sel = me;
            endcase
        end

        assign result[i*W +: W] = lane_d[sel];

        always_comb begin
            if (m != MODE_PERM) begin
                p_same_segment_r6: assert ((sel & ~mask) == base)
                    else $error("lane %0d read outside its segment", i);
            end
        end
    end

endmodule

// File: rtl/lane_shuf_ctrl.sv
module lane_shuf_ctrl
    import lane_shuf_pkg::*;
#(
    parameter int DW = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          out_valid,
    input  logic          out_ready,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    hold_state_e state_q;
    hold_state_e state_d;
    logic        take;

    assign take = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_EMPTY: if (in_valid) state_d = S_FULL;
            S_FULL:  if (out_ready && !in_valid) state_d = S_EMPTY;
            default: state_d = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        in_ready  = (state_q == S_EMPTY) || out_ready;
        out_valid = (state_q == S_FULL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (take) q <= d;
    end

    p_valid_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_drain_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(q)));

endmodule

// File: rtl/lane_shuf_top.sv
module lane_shuf_top #(
    parameter int N  = 32,
    parameter int W  = 32,
    parameter int LW = $clog2(N),
    parameter int SW = LW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [1:0]      in_mode,
    input  logic [LW-1:0]   in_operand,
    input  logic [SW-1:0]   in_seg_width,
    input  logic [N*W-1:0]  in_data,
    input  logic [N*LW-1:0] in_src,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [N*W-1:0]  out_data
);
    logic [SW-1:0]  seg_eff;
    logic [N*W-1:0] routed;

    lane_shuf_width #(.N(N), .LW(LW), .SW(SW)) u_width (
        .seg_req (in_seg_width),
        .seg_eff (seg_eff)
    );

    lane_shuf_route #(.N(N), .W(W), .LW(LW), .SW(SW)) u_route (
        .mode    (in_mode),
        .operand (in_operand),
        .seg_w   (seg_eff),
        .data    (in_data),
        .srcs    (in_src),
        .result  (routed)
    );

    lane_shuf_ctrl #(.DW(N*W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .d         (routed),
        .q         (out_data)
    );

    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready));

endmodule

// File: tb/lane_shuf_top_tb.sv
module lane_shuf_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int W  = 8;
    localparam int LW = 3;
    localparam int SW = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic            in_ready;
    logic [1:0]      in_mode;
    logic [LW-1:0]   in_operand;
    logic [SW-1:0]   in_seg_width;
    logic [N*W-1:0]  in_data;
    logic [N*LW-1:0] in_src;
    logic            out_valid;
    logic            out_ready;
    logic [N*W-1:0]  out_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_shuf_top #(.N(N), .W(W), .LW(LW), .SW(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_operand(in_operand), .in_seg_width(in_seg_width),
        .in_data(in_data), .in_src(in_src), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int eff_width(input int s);
        if (s >= 2 && s <= N && (s & (s - 1)) == 0) return s;
        return N;
    endfunction

    function automatic logic [N*W-1:0] model(input int mode, input int s_req, input int op,
                                             input logic [N*W-1:0] d, input logic [N*LW-1:0] sv);
        logic [N*W-1:0] r;
        int s = eff_width(s_req);
        for (int i = 0; i < N; i++) begin
            int base = (i / s) * s;
            int off  = i % s;
            int src;
            case (mode)
                0: src = base + (op % s);
                1: src = (off >= op) ? i - op : i;
                2: src = base + ((off ^ op) % s);
                default: src = int'(sv[i*LW +: LW]);
            endcase
            r[i*W +: W] = d[src*W +: W];
        end
        return r;
    endfunction

    function automatic logic [N*W-1:0] mk_data(input int seed);
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) r[i*W +: W] = W'(i * 29 + seed * 7 + 1);
        return r;
    endfunction

    function automatic logic [N*LW-1:0] mk_src(input int k);
        logic [N*LW-1:0] r;
        for (int i = 0; i < N; i++) r[i*LW +: LW] = LW'((i * 3 + k * 7) % N);
        return r;
    endfunction

    task automatic drive(input int mode, input int s, input int op, input int seed);
        in_valid     = 1'b1;
        in_mode      = 2'(mode);
        in_seg_width = SW'(s);
        in_operand   = LW'(op);
        in_data      = mk_data(seed);
        in_src       = mk_src(seed);
    endtask

    task automatic txn(input int mode, input int s, input int op, input int seed, input string req);
        logic [N*W-1:0] exp;
        @(negedge clk);
        drive(mode, s, op, seed);
        out_ready = 1'b1;
        exp = model(mode, s, op, in_data, in_src);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, {req, " R8 valid"}, 64'(out_valid), 64'd1);
        chk(out_data == exp, req, out_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] exp_a;
        logic [N*W-1:0] exp_b;
        int seed = 0;
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        in_mode = '0; in_operand = '0; in_seg_width = '0; in_data = '0; in_src = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R10 reset", {62'd0, out_valid, in_ready}, 64'd1);
        rst_n = 1'b1;

        // R3 directed: distance beyond segment keeps every lane's own word
        txn(1, 4, 5, 99, "R3 shift beyond segment");
        chk(out_data == mk_data(99), "R3 own word kept", out_data, mk_data(99));

        // R7 directed: width 3 must match width 8
        txn(0, 3, 5, 77, "R7 width 3");
        exp_a = mk_data(77);
        chk(out_data == {N{exp_a[5*W +: W]}}, "R7 broadcast whole wave", out_data, {N{exp_a[5*W +: W]}});

        // sweep all modes, widths, operands
        for (int mode = 0; mode < 4; mode++) begin
            for (int s = 0; s < 16; s++) begin
                for (int op = 0; op < N; op++) begin
                    string tag;
                    case (mode)
                        0: tag = "R1";
                        1: tag = "R2/R3";
                        2: tag = "R4";
                        default: tag = "R5";
                    endcase
                    tag = {tag, (eff_width(s) == s) ? " R6" : " R7"};
                    seed++;
                    txn(mode, s, op, seed, tag);
                end
            end
        end

        // R8 drain without new request drops valid
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 drained", 64'(out_valid), 64'd0);

        // R9 backpressure
        @(negedge clk);
        drive(2, 4, 1, 500);
        out_ready = 1'b0;
        exp_a = model(2, 4, 1, in_data, in_src);
        @(negedge clk);
        drive(0, 8, 6, 501);
        exp_b = model(0, 8, 6, in_data, in_src);
        for (int k = 0; k < 3; k++) begin
            chk(out_valid == 1'b1 && in_ready == 1'b0, "R9 stall ready low",
                {62'd0, out_valid, in_ready}, 64'd2);
            chk(out_data == exp_a, "R9 held data", out_data, exp_a);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R9 queued valid", 64'(out_valid), 64'd1);
        chk(out_data == exp_b, "R9 queued data", out_data, exp_b);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 final drain", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule